// File: doc/BRIEF.md
# Prescaled Interval Timer with Watchdog Mode

This block is a register-mapped interval timer. A 16-bit prescaler divides the input clock and a 16-bit period counter counts the prescaled ticks. The end of a period lasts prescaler × period input clocks. The timer can run once or repeat. In normal operation, each period end sets an event flag and can raise an interrupt.

When watchdog mode is on, a period end instead emits a one-cycle reset request and halts the timer. Software keeps the watchdog from firing by writing a service key into the top byte of the mode word. That write starts the period over and leaves every other mode field as it was.

Software reaches three 32-bit words (mode, count, status) through a simple write bus with byte enables. Reads are combinational by word index.

Top module: `ptw_timer_top`

## Requirements
- R1: After reset, the mode, count and status words all read zero, and `irq_o` and `reset_req_o` are low.
- R2: The count word (word index 1) holds the prescaler in bits 31:16 and the period in bits 15:0. A period end happens prescaler × period clocks after the counter starts. A field value of 0 counts as 65536.
- R3: The counter advances only when the enable bit (mode bit 12) is set and the function field (mode bits 2:0) equals 4. While the counter is halted, no period end occurs. Re-enabling the counter starts a fresh period.
- R4: With the continuous bit (mode bit 10) clear, a period end sets status bit 0 and the hardware clears mode bit 12.
- R5: With mode bit 10 set, the counter reloads at every period end, sets status bit 0 each time, and keeps mode bit 12 set.
- R6: Status bits 3:0 (word index 2) are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R7: `irq_o` is high exactly when interrupt enable (mode bit 8) is set, watchdog mode is off, and some status flag is set.
- R8: With watchdog mode (mode bit 15) set, a period end drives `reset_req_o` high for one cycle. It leaves status and `irq_o` untouched and clears mode bit 12.
- R9: A write of 0xA5 into mode bits 31:24 (byte enable 3) restarts the current period and changes no other mode bit.
- R10: A write of any other value into mode bits 31:24 has no effect.
- R11: Writing the count word while the counter runs restarts the period at once using the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 2 | Word index: 0 mode, 1 count, 2 status |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the indexed word |
| irq_o | output | 1 | Interrupt request |
| reset_req_o | output | 1 | One-cycle watchdog reset request |

## Verification
The bench measures the period end to the exact clock, both at the nominal product and at the zero-means-65536 case. An off-by-one in the prescaler or period compare would show up as a flag one cycle early or late. It reloads the count word while the counter is running and checks that the old expiry point passes silently. A design that ignored the reload would flag at the old time.

In watchdog mode, the bench services the timer partway through a period with the correct key and, separately, with a wrong one. A design that decoded the key loosely, or stored byte 3 into the mode word, would either miss the restart or corrupt the enable bits. The bench also checks that the reset request lasts exactly one cycle and stays away afterwards. A design that kept counting would fire it again.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int WORD_W  = 32;
    localparam int FIELD_W = 16;
    localparam int STAGES  = 2;

    localparam logic [2:0] FN_TIMER    = 3'd4;
    localparam logic [7:0] SERVICE_KEY = 8'hA5;

    localparam int B_IRQ_EN = 8;
    localparam int B_CONT   = 10;
    localparam int B_RUN    = 12;
    localparam int B_WDOG   = 15;

    typedef enum logic [1:0] {
        SEL_MODE   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       wdog;
        logic       run;
        logic       cont;
        logic       irq_en;
        logic [2:0] func;
    } mode_t;

    typedef struct packed {
        logic [FIELD_W-1:0] presc;
        logic [FIELD_W-1:0] period;
    } count_t;

    function automatic logic [WORD_W-1:0] mode_to_word(input mode_t m);
        logic [WORD_W-1:0] w;
        w           = '0;
        w[2:0]      = m.func;
        w[B_IRQ_EN] = m.irq_en;
        w[B_CONT]   = m.cont;
        w[B_RUN]    = m.run;
        w[B_WDOG]   = m.wdog;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] merge_bytes(input logic [WORD_W-1:0] old_w,
                                                      input logic [WORD_W-1:0] new_w,
                                                      input logic [WORD_W/8-1:0] be);
        logic [WORD_W-1:0] w;
        w = old_w;
        for (int b = 0; b < WORD_W/8; b++) begin
            if (be[b]) w[b*8 +: 8] = new_w[b*8 +: 8];
        end
        return w;
    endfunction

endpackage

// File: rtl/ptw_tick_chain.sv
module ptw_tick_chain #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      run,
    input  logic                      restart,
    input  logic [STAGES-1:0][W-1:0]  limit,
    output logic                      done
);
    logic [STAGES:0] carry;
    assign carry[0] = 1'b1;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [W-1:0] cnt_q;
        logic         at_last;

        // limit of zero wraps to all-ones, giving 2**W steps
        assign at_last      = (cnt_q == limit[i] - W'(1));
        assign carry[i+1]   = carry[i] & at_last;

        always_ff @(posedge clk) begin
            if (rst || !run || restart) begin
                cnt_q <= '0;
            end else if (carry[i]) begin
                cnt_q <= at_last ? '0 : cnt_q + W'(1);
            end
        end
    end

    assign done = run & ~restart & carry[STAGES];
endmodule

// File: rtl/ptw_ctrl_regs.sv
module ptw_ctrl_regs
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_mode,
    input  logic              wr_count,
    input  logic              wr_status,
    input  logic [3:0]        be,
    input  logic [WORD_W-1:0] wdata,
    input  logic              period_end,
    output mode_t             mode_q,
    output count_t            count_q,
    output logic [3:0]        status_q,
    output logic              restart,
    output logic              reset_req_o
);
    mode_t      mode_n;
    logic [3:0] status_n;
    logic       service;

    assign service = wr_mode && be[3] && (wdata[31:24] == SERVICE_KEY);
    assign restart = service || wr_count;

    always_comb begin
        mode_n = mode_q;
        if (period_end && (mode_q.wdog || !mode_q.cont)) mode_n.run = 1'b0;
        if (wr_mode && be[0]) mode_n.func = wdata[2:0];
        if (wr_mode && be[1]) begin
            mode_n.irq_en = wdata[B_IRQ_EN];
            mode_n.cont   = wdata[B_CONT];
            mode_n.run    = wdata[B_RUN];
            mode_n.wdog   = wdata[B_WDOG];
        end
    end

    always_comb begin
        status_n = status_q;
        if (wr_status && be[0]) status_n = status_n & ~wdata[3:0];
        if (period_end && !mode_q.wdog) status_n[0] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= '0;
            count_q     <= '0;
            status_q    <= '0;
            reset_req_o <= 1'b0;
        end else begin
            mode_q      <= mode_n;
            status_q    <= status_n;
            reset_req_o <= period_end && mode_q.wdog;
            if (wr_count) count_q <= count_t'(merge_bytes(WORD_W'(count_q), wdata, be));
        end
    end
endmodule

// File: rtl/ptw_timer_top.sv
module ptw_timer_top
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              reset_req_o
);
    mode_t      mode_q;
    count_t     count_q;
    logic [3:0] status_q;
    logic       restart;
    logic       period_end;
    logic       run;
    logic       wr_any;
    logic       wr_mode, wr_count, wr_status;
    logic       mode_hi_wr;
    reg_sel_e   sel;
    logic [STAGES-1:0][FIELD_W-1:0] limits;

    assign sel        = reg_sel_e'(bus_addr);
    assign wr_any     = bus_sel && bus_wr;
    assign wr_mode    = wr_any && (sel == SEL_MODE);
    assign wr_count   = wr_any && (sel == SEL_COUNT);
    assign wr_status  = wr_any && (sel == SEL_STATUS);
    assign mode_hi_wr = wr_mode && bus_be[1];

    assign run    = mode_q.run && (mode_q.func == FN_TIMER);
    assign limits = {count_q.period, count_q.presc};

    ptw_ctrl_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_mode     (wr_mode),
        .wr_count    (wr_count),
        .wr_status   (wr_status),
        .be          (bus_be),
        .wdata       (bus_wdata),
        .period_end  (period_end),
        .mode_q      (mode_q),
        .count_q     (count_q),
        .status_q    (status_q),
        .restart     (restart),
        .reset_req_o (reset_req_o)
    );

    ptw_tick_chain #(.W(FIELD_W), .STAGES(STAGES)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (restart),
        .limit   (limits),
        .done    (period_end)
    );

    assign irq_o = mode_q.irq_en && !mode_q.wdog && (|status_q);

    always_comb begin
        case (sel)
            SEL_MODE:   bus_rdata = mode_to_word(mode_q);
            SEL_COUNT:  bus_rdata = WORD_W'(count_q);
            SEL_STATUS: bus_rdata = {{(WORD_W-4){1'b0}}, status_q};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
    input logic clk,
    input logic rst,
    input logic period_end,
    input logic wdog,
    input logic cont,
    input logic en,
    input logic flag0,
    input logic mode_hi_wr,
    input logic reset_req
);
    // R8: the reset request never lasts more than one cycle
    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);

    // R8: a watchdog period end produces the request
    assert_req_follows_end_R8: assert property (@(posedge clk) disable iff (rst)
        (period_end && wdog) |=> reset_req);

    // R8: the request coincides with the counter being halted
    assert_req_halts_R8: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> !en);

    // R4: a normal period end raises the event flag
    assert_flag_follows_end_R4: assert property (@(posedge clk) disable iff (rst)
        (period_end && !wdog) |=> flag0);

    // R4: one-shot halts after its period
    assert_oneshot_halts_R4: assert property (@(posedge clk) disable iff (rst)
        (period_end && !cont && !mode_hi_wr) |=> !en);

    // R5: continuous mode keeps running through a period end
    assert_cont_keeps_run_R5: assert property (@(posedge clk) disable iff (rst)
        (period_end && cont && !wdog && !mode_hi_wr) |=> en);
endmodule

bind ptw_timer_top ptw_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .period_end (period_end),
    .wdog       (mode_q.wdog),
    .cont       (mode_q.cont),
    .en         (mode_q.run),
    .flag0      (status_q[0]),
    .mode_hi_wr (mode_hi_wr),
    .reset_req  (reset_req_o)
);

// File: tb/ptw_timer_top_tb_top.sv
module ptw_timer_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [3:0]  bus_be = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        reset_req_o;

    int checks = 0;
    int fails  = 0;

    localparam logic [1:0] A_MODE = 2'd0, A_COUNT = 2'd1, A_STAT = 2'd2;

    always #4 clk = ~clk;

    ptw_timer_top dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .reset_req_o(reset_req_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // called at a falling edge; write takes effect at the next rising edge
    task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'h0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_MODE, v);  check("R1", "mode", v, 32'h0);
        rd(A_COUNT, v); check("R1", "count", v, 32'h0);
        rd(A_STAT, v);  check("R1", "status", v, 32'h0);
        check("R1", "irq", 32'(irq_o), 32'h0);
        check("R1", "reset_req", 32'(reset_req_o), 32'h0);
    endtask

    task automatic t_oneshot;
        logic [31:0] v;
        wr(A_COUNT, 4'hF, 32'h0003_0004);
        wr(A_MODE, 4'hF, 32'h0000_1104);
        wait_edges(11);
        rd(A_STAT, v); check("R2", "status before 12 clocks", v, 32'h0);
        wait_edges(1);
        rd(A_STAT, v); check("R4", "status at 12 clocks", v, 32'h1);
        rd(A_MODE, v); check("R4", "enable cleared", v, 32'h0000_0104);
        check("R7", "irq with flag", 32'(irq_o), 32'h1);
        wr(A_MODE, 4'h3, 32'h0000_0004);
        check("R7", "irq masked", 32'(irq_o), 32'h0);
        wr(A_MODE, 4'h3, 32'h0000_0104);
        check("R7", "irq unmasked", 32'(irq_o), 32'h1);
        wr(A_STAT, 4'h1, 32'h0000_0000);
        rd(A_STAT, v); check("R6", "write zero keeps flag", v, 32'h1);
        wr(A_STAT, 4'h1, 32'h0000_000F);
        rd(A_STAT, v); check("R6", "write one clears", v, 32'h0);
        check("R7", "irq after clear", 32'(irq_o), 32'h0);
        wr(A_MODE, 4'hF, 32'h0);
    endtask

    task automatic t_func_gate;
        logic [31:0] v;
        wr(A_COUNT, 4'hF, 32'h0002_0002);
        wr(A_MODE, 4'hF, 32'h0000_1003);
        wait_edges(20);
        rd(A_STAT, v); check("R3", "no count with function 3", v, 32'h0);
        wr(A_MODE, 4'h1, 32'h0000_0004);
        wait_edges(3);
        rd(A_STAT, v); check("R3", "fresh period not yet", v, 32'h0);
        wait_edges(1);
        rd(A_STAT, v); check("R3", "fresh period end", v, 32'h1);
        wr(A_STAT, 4'h1, 32'h1);
        wr(A_MODE, 4'hF, 32'h0);
    endtask

    task automatic t_continuous;
        logic [31:0] v;
        wr(A_COUNT, 4'hF, 32'h0002_0003);
        wr(A_MODE, 4'hF, 32'h0000_1404);
        wait_edges(6);
        rd(A_STAT, v); check("R5", "first period", v, 32'h1);
        wr(A_STAT, 4'h1, 32'h1);
        wait_edges(4);
        rd(A_STAT, v); check("R5", "between periods", v, 32'h0);
        wait_edges(1);
        rd(A_STAT, v); check("R5", "second period", v, 32'h1);
        rd(A_MODE, v); check("R5", "still enabled", v, 32'h0000_1404);
        wr(A_MODE, 4'hF, 32'h0000_0404);
        wr(A_STAT, 4'h1, 32'h1);
        wait_edges(20);
        rd(A_STAT, v); check("R3", "stopped counter", v, 32'h0);
    endtask

    task automatic t_reload;
        logic [31:0] v;
        wr(A_COUNT, 4'hF, 32'h0002_0005);
        wr(A_MODE, 4'hF, 32'h0000_1404);
        wait_edges(7);
        wr(A_COUNT, 4'hF, 32'h0001_0003);
        wait_edges(2);
        rd(A_STAT, v); check("R11", "old expiry suppressed", v, 32'h0);
        wait_edges(1);
        rd(A_STAT, v); check("R11", "new period end", v, 32'h1);
        wr(A_MODE, 4'hF, 32'h0);
        wr(A_STAT, 4'h1, 32'h1);
    endtask

    task automatic t_wdog;
        logic [31:0] v;
        wr(A_COUNT, 4'hF, 32'h0002_0004);
        wr(A_MODE, 4'hF, 32'h0000_9104);
        wait_edges(7);
        check("R8", "req before expiry", 32'(reset_req_o), 32'h0);
        wait_edges(1);
        check("R8", "req at expiry", 32'(reset_req_o), 32'h1);
        rd(A_STAT, v); check("R8", "no status", v, 32'h0);
        check("R8", "no irq", 32'(irq_o), 32'h0);
        rd(A_MODE, v); check("R8", "halted", v, 32'h0000_8104);
        wait_edges(1);
        check("R8", "pulse one cycle", 32'(reset_req_o), 32'h0);
        wait_edges(20);
        check("R8", "no repeat", 32'(reset_req_o), 32'h0);
    endtask

    task automatic t_service;
        logic [31:0] v;
        wr(A_MODE, 4'hF, 32'h0000_9004);
        wait_edges(5);
        wr(A_MODE, 4'h8, 32'hA500_0000);
        rd(A_MODE, v); check("R9", "mode kept", v, 32'h0000_9004);
        wait_edges(7);
        check("R9", "serviced, no req", 32'(reset_req_o), 32'h0);
        wait_edges(1);
        check("R9", "req after restarted period", 32'(reset_req_o), 32'h1);
        wr(A_MODE, 4'hF, 32'h0000_9004);
        wait_edges(5);
        wr(A_MODE, 4'h8, 32'h5A00_0000);
        rd(A_MODE, v); check("R10", "mode kept on bad key", v, 32'h0000_9004);
        wait_edges(1);
        check("R10", "no req yet", 32'(reset_req_o), 32'h0);
        wait_edges(1);
        check("R10", "bad key did not restart", 32'(reset_req_o), 32'h1);
        wr(A_MODE, 4'hF, 32'h0);
    endtask

    task automatic t_zero_fields;
        logic [31:0] v;
        wr(A_COUNT, 4'hF, 32'h0000_0001);
        wr(A_MODE, 4'hF, 32'h0000_1004);
        wait_edges(65535);
        rd(A_STAT, v); check("R2", "prescaler 0 early", v, 32'h0);
        wait_edges(1);
        rd(A_STAT, v); check("R2", "prescaler 0 end", v, 32'h1);
        wr(A_STAT, 4'h1, 32'h1);
        wr(A_COUNT, 4'hF, 32'h0001_0000);
        wr(A_MODE, 4'hF, 32'h0000_1004);
        wait_edges(65535);
        rd(A_STAT, v); check("R2", "period 0 early", v, 32'h0);
        wait_edges(1);
        rd(A_STAT, v); check("R2", "period 0 end", v, 32'h1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_oneshot();
        t_func_gate();
        t_continuous();
        t_reload();
        t_wdog();
        t_service();
        t_zero_fields();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule